// File: doc/BRIEF.md
# Vsync-Clocked Display Data Shifter

This block is the transmit side of the legacy one-way display data channel. A host CPU writes a byte into a holding latch. The block then sends bytes serially on a data pin, advancing one bit for each rising edge of the monitor's vertical sync input. Each frame carries eight data bits, most significant first, and then a ninth bit whose level is chosen by a control input. On the edge that follows the ninth bit, the latch contents move into the shift register. On the falling edge of that same sync pulse, a buffer-empty interrupt asks the CPU for the next byte. Writing the latch clears the interrupt.

Vsync is never used as a clock. It passes through a two-stage synchronizer into the system clock domain and is edge-detected there. The block has a defined power-up sequence. Reset zeroes the shift register and the bit position, but the latch keeps whatever it held. The first frame after reset therefore carries no loaded data: it is eight zeros and then the ninth bit. When the enable is low, the frame state is frozen and the pin idles high.

Top module: `vs_ddc_tx`

## Requirements
- R1: Reset returns the bit position to the start of a frame, zeroes the shift register and clears the interrupt. With the enable high after reset, `sda_o` is 0 and `irq_o` is 0.
- R2: While `enable_i` is 0, `sda_o` is 1. Vsync edges neither advance the frame nor raise the interrupt. After the enable is set again, the frame resumes at the bit where it stopped.
- R3: The first frame after reset shows 0 before any edge and after each of rising edges 1 to 7. The ninth bit appears after edge 8. The latch is loaded on edge 9.
- R4: Within a frame, the 8 data bits of the loaded byte appear on `sda_o` most significant bit first, one bit per Vsync rising edge.
- R5: The ninth bit of every frame shows the level of `ninth_sel_i`: 1 when the input is set, 0 when it is clear.
- R6: The rising edge that follows a ninth bit loads the latch into the shift register and puts latch bit 7 on `sda_o`. Frames therefore repeat every 9 rising edges.
- R7: `irq_o` rises on the falling edge of the Vsync pulse whose rising edge caused a load. It does not rise on that rising edge.
- R8: A latch write (`wr_en_i` high for one clock) clears `irq_o` at the next clock edge.
- R9: A latch write in the middle of a frame leaves the bits of that frame unchanged. The new byte is sent in the next frame.
- R10: A Vsync rising edge changes `sda_o` at the third rising clock edge after the input goes high, and not before. Vsync high and low times must each last at least 3 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vsync_i | input | 1 | Vertical sync input, asynchronous, used as the shift strobe |
| enable_i | input | 1 | 1 runs the shifter, 0 freezes it and drives the pin high |
| ninth_sel_i | input | 1 | Level of the ninth bit of each frame |
| wr_en_i | input | 1 | One-cycle strobe that writes the latch and clears the interrupt |
| wr_data_i | input | 8 | Byte written into the latch |
| sda_o | output | 1 | Serial data out |
| irq_o | output | 1 | Buffer-empty interrupt, level, cleared by a write |

## Verification
A wrong bit position misplaces the ninth bit and the load within a few Vsync pulses. It then shows on `sda_o` as a byte rotated against the 9-edge frame grid, and stays that way for every later frame. A shift register error corrupts a visible data bit on the next rising edge, three clocks after Vsync rises. A broken interrupt flag shows one falling edge late, early or never. Each Vsync pulse is checked at three points: two clocks after the rise, when the output must be unchanged; three clocks after the rise; and after the fall. This way a drift of a single clock or a single edge is caught on the first affected pulse.

// File: rtl/vs_ddc_pkg.sv
package vs_ddc_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } vs_edge_t;
endpackage

// File: rtl/vs_edge_sync.sv
module vs_edge_sync
  import vs_ddc_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     async_i,
  output vs_edge_t edge_o
);
  // chain[STAGES] holds the previous synchronized value
  logic [STAGES:0] chain_q;

  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= 1'b0;
      else if (g == 0) chain_q[g] <= async_i;
      else chain_q[g] <= chain_q[g-1];
    end
  end

  assign edge_o.rise = chain_q[STAGES-1] & ~chain_q[STAGES];
  assign edge_o.fall = ~chain_q[STAGES-1] & chain_q[STAGES];

  // R10
  edge_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o.rise |=> !edge_o.rise);
endmodule

// File: rtl/ddc_frame_shift.sv
module ddc_frame_shift #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned POS_W = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              ninth_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic              bit_o,
  output logic              load_o
);
  localparam logic [POS_W-1:0] LAST = POS_W'(DATA_W);

  logic [DATA_W-1:0] sh_q;
  logic [POS_W-1:0]  pos_q;

  assign load_o = step_i && (pos_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      pos_q <= '0;
    end else if (step_i) begin
      if (pos_q == LAST) begin
        sh_q  <= load_data_i;
        pos_q <= '0;
      end else begin
        sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assign bit_o = (pos_q == LAST) ? ninth_i : sh_q[DATA_W-1];

  // R6
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && pos_q == LAST) |=> (pos_q == '0) && (sh_q == $past(load_data_i)));
  // R4
  pos_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= LAST);
  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(pos_q) && $stable(sh_q));
endmodule

// File: rtl/ddc_buf_irq.sv
module ddc_buf_irq #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              load_i,
  input  logic              fall_i,
  output logic [DATA_W-1:0] buf_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] buf_q;
  logic              pend_q, irq_q;

  // latch buffer intentionally has no reset
  always_ff @(posedge clk_i) begin
    if (wr_en_i) buf_q <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (load_i) pend_q <= 1'b1;
      else if (fall_i) pend_q <= 1'b0;
      if (fall_i && pend_q) irq_q <= 1'b1;
      else if (wr_en_i) irq_q <= 1'b0;
    end
  end

  assign buf_o = buf_q;
  assign irq_o = irq_q;

  // R7
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(fall_i));
  // R8
  irq_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && wr_en_i && !(fall_i && pend_q)) |=> !irq_q);
endmodule

// File: rtl/vs_ddc_tx.sv
module vs_ddc_tx
  import vs_ddc_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vsync_i,
  input  logic              enable_i,
  input  logic              ninth_sel_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              sda_o,
  output logic              irq_o
);
  vs_edge_t          vs_edge;
  logic              shift_bit, load;
  logic [DATA_W-1:0] buf_data;

  vs_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(vsync_i),
    .edge_o (vs_edge)
  );

  ddc_frame_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (vs_edge.rise & enable_i),
    .ninth_i    (ninth_sel_i),
    .load_data_i(buf_data),
    .bit_o      (shift_bit),
    .load_o     (load)
  );

  ddc_buf_irq #(.DATA_W(DATA_W)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .load_i   (load),
    .fall_i   (vs_edge.fall & enable_i),
    .buf_o    (buf_data),
    .irq_o    (irq_o)
  );

  assign sda_o = enable_i ? shift_bit : 1'b1;

  // R2
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !$past(enable_i)) |-> sda_o && $stable(irq_o) || (!enable_i && wr_en_i) || $past(wr_en_i));
endmodule

// File: tb/vs_ddc_tx_bench.sv
module vs_ddc_tx_bench;
  logic       clk = 1'b0, rst_n = 1'b0, vsync = 1'b0, en = 1'b0, ninth = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       sda, irq;

  int n_chk = 0, n_bad = 0;
  int m_pos;
  logic [7:0] m_sh, m_buf;
  logic m_pend, m_irq, m_first;

  always #4 clk = ~clk;

  vs_ddc_tx u_vs_ddc_tx (
    .clk_i(clk), .rst_ni(rst_n), .vsync_i(vsync), .enable_i(en),
    .ninth_sel_i(ninth), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .sda_o(sda), .irq_o(irq)
  );

  function automatic logic exp_sda();
    if (!en) return 1'b1;
    return (m_pos == 8) ? ninth : m_sh[7];
  endfunction

  task automatic chk(string tag, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b (t=%0t)", tag, got, exp, $time);
    end
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk) wr_en = 1'b1; wr_data = d;
    @(negedge clk) wr_en = 1'b0;
    m_buf = d; m_irq = 1'b0;
    chk("R8 irq cleared by write", irq, 1'b0);
    chk("R9 frame undisturbed by write", sda, exp_sda());
  endtask

  task automatic pulse();
    logic old_b, new_b;
    string tag;
    old_b = exp_sda();
    if (en) begin
      if (m_pos == 8) begin
        m_sh = m_buf; m_pos = 0; m_pend = 1'b1; m_first = 1'b0;
      end else begin
        m_sh = m_sh << 1; m_pos++;
      end
    end
    new_b = exp_sda();
    if (!en) tag = "R2 disabled";
    else if (m_first) tag = "R3 first frame";
    else if (m_pos == 8) tag = "R5 ninth bit";
    else if (m_pos == 0) tag = "R6 load D7";
    else tag = "R4 data bit";
    @(negedge clk) vsync = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk) chk("R10 no early change", sda, old_b);
    @(posedge clk);
    @(negedge clk) chk(tag, sda, new_b);
    chk("R7 no irq at rise", irq, m_irq);
    repeat (2) @(posedge clk);
    @(negedge clk) vsync = 1'b0;
    if (en && m_pend) begin m_pend = 1'b0; m_irq = 1'b1; end
    repeat (4) @(posedge clk);
    @(negedge clk) chk("R7 irq after fall", irq, m_irq);
  endtask

  task automatic set_en(logic v);
    @(negedge clk) en = v;
    #1 chk("R2 enable level", sda, exp_sda());
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed_1234);
    m_pos = 0; m_sh = '0; m_buf = '0; m_pend = 1'b0; m_irq = 1'b0; m_first = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    set_en(1'b1);
    chk("R1 sda after reset", sda, 1'b0);
    chk("R1 irq after reset", irq, 1'b0);
    wr(8'hA5);
    ninth = 1'b1;
    // R3 power-up frame: zeros, ninth, then load
    for (int i = 0; i < 9; i++) pulse();
    wr(8'h3C);
    ninth = 1'b0;
    for (int i = 0; i < 4; i++) pulse();
    // R9 mid-frame write
    wr(8'hF0);
    for (int i = 0; i < 5; i++) pulse();
    // R2 freeze mid-frame
    for (int i = 0; i < 3; i++) pulse();
    set_en(1'b0);
    for (int i = 0; i < 3; i++) pulse();
    set_en(1'b1);
    for (int i = 0; i < 15; i++) pulse();
    // randomized stretch
    for (int i = 0; i < 500; i++) begin
      int unsigned r;
      r = $urandom % 100;
      if (r < 5) set_en(~en);
      if (r < 25) ninth = 1'($urandom % 2);
      if (m_irq && ($urandom % 2 == 1)) wr(8'($urandom));
      else if (r > 90) wr(8'($urandom));
      pulse();
    end
    report();
  end
endmodule